// File: doc/BRIEF.md
# Lane Min/Max Video ALU

This block is a 32-bit datapath that picks the smaller or the larger of two integer operands and then combines the pick with a third operand. Operand A always comes from a 32-bit source word. A lane code selects one of its four bytes, one of its two halfwords, or the whole word. A separate flag says whether the selected lane is sign-extended or zero-extended to 32 bits. Operand B is built the same way from a second source word, or it is taken from a 16-bit immediate. The two operands may differ in signedness. The comparison is still exact, because both operands are widened to 33 bits before they are compared.

Saturation is optional. It clamps the pick into the range of the destination format. After that comes a post step against operand C. The post step can pass the value through, add C to it, take a further min or max with C, or write the value's low halfword or low byte into one lane of C. The final value is captured in an output register. A parameter can remove that register and make the path purely combinational.

Top module: `lane_minmax_alu`

## Requirements
- R1: Lane code for A: 0 to 3 select byte 0 to 3 (byte k is bits 8k+7..8k). 4 selects bits 15..0 and 5 selects bits 31..16. 6 and 7 select the whole word. The selected lane is sign-extended when `a_signed` is 1 and zero-extended when it is 0.
- R2: When `b_use_imm` is 1, B is `imm` sign-extended to 32 bits if `b_signed` is 1 and zero-extended otherwise. In that case `src_b` and `b_lane` have no effect. When `b_use_imm` is 0, B is taken from `src_b` by the rule of R1.
- R3: `pick_max` = 1 yields the larger operand and 0 yields the smaller. When both operands have the same signedness, the comparison uses that signedness.
- R4: With mixed signedness the comparison is exact over the full value range. For example, the larger of unsigned 0x80000000 and signed 5 is 0x80000000, and the smaller of unsigned 0x80000000 and signed −3 is 0xFFFFFFFD.
- R5: The pick's signedness is the operands' common signedness. With mixed operands, a max is treated as unsigned and a min as signed.
- R6: If `sat_en` = 1, `dst_signed` = 1 and the pick is unsigned, the pick is clamped to at most 0x7FFFFFFF.
- R7: If `sat_en` = 1, `dst_signed` = 0 and the pick is signed, a negative pick becomes 0.
- R8: In every other combination, saturation leaves the pick unchanged.
- R9: Post code 1 adds C modulo 2^32.
- R10: Post codes 2 (max) and 3 (min) compare with C as signed values when `dst_signed` = 1 and as unsigned values otherwise. Post code 0 passes the value through.
- R11: Post code 4 writes the low 16 bits of the value into bits 31..16 of C. Code 5 writes them into bits 15..0. Code 6 writes the low byte into bits 7..0 and code 7 writes it into bits 23..16. All other bits of C are kept.
- R12: With `OUT_REG` = 1 (the default), `result` changes one clock after the inputs, holds between edges, and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 32 | Source word for A |
| src_b | input | 32 | Source word for B |
| src_c | input | 32 | Third operand for the post step |
| imm | input | 16 | Immediate for B |
| a_lane | input | 3 | Lane code for A |
| a_signed | input | 1 | Sign-extend A |
| b_lane | input | 3 | Lane code for B |
| b_signed | input | 1 | Sign-extend B or the immediate |
| b_use_imm | input | 1 | Take B from the immediate |
| pick_max | input | 1 | 1 = max, 0 = min |
| sat_en | input | 1 | Enable saturation |
| dst_signed | input | 1 | Destination format is signed |
| post_sel | input | 3 | Post-step code |
| result | output | 32 | Final value |

## Verification
Saturation and the post step can act on the same operation, and the order between them matters. One test sets up a mixed-signedness max that clamps to 0x7FFFFFFF and then accumulates C = 1. The expected result is 0x80000000, which is only correct if the clamp happens before the add. A second test pairs a clamp to 0 with a byte merge, and the check confirms that the merged lane holds the clamped value.

// File: rtl/lmm_pkg.sv
package lmm_pkg;
    localparam int DW = 32;
    localparam int HW = DW / 2;
    localparam int BW = 8;

    typedef enum logic [2:0] {
        POST_NONE    = 3'd0,
        POST_ADD     = 3'd1,
        POST_MAX     = 3'd2,
        POST_MIN     = 3'd3,
        POST_INS_H16 = 3'd4,
        POST_INS_L16 = 3'd5,
        POST_INS_B0  = 3'd6,
        POST_INS_B2  = 3'd7
    } post_e;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          sgn;
    } operand_t;
endpackage

// File: rtl/lmm_lane_ext.sv
module lmm_lane_ext
    import lmm_pkg::*;
(
    input  logic [DW-1:0] word,
    input  logic [2:0]    lane,
    input  logic          sgn,
    output operand_t      opnd
);
    localparam int NBYTE = DW / BW;

    logic [BW-1:0] bytes [NBYTE];
    logic [HW-1:0] halves [2];

    genvar gi;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_byte
            assign bytes[gi] = word[gi*BW +: BW];
        end
        for (gi = 0; gi < 2; gi++) begin : g_half
            assign halves[gi] = word[gi*HW +: HW];
        end
    endgenerate

    always_comb begin
        opnd.sgn = sgn;
        if (lane[2] == 1'b0) begin
            opnd.value = {{(DW-BW){sgn & bytes[lane[1:0]][BW-1]}}, bytes[lane[1:0]]};
        end else if (lane[1] == 1'b0) begin
            opnd.value = {{(DW-HW){sgn & halves[lane[0]][HW-1]}}, halves[lane[0]]};
        end else begin
            opnd.value = word;
        end
    end
endmodule

// File: rtl/lmm_pick.sv
module lmm_pick
    import lmm_pkg::*;
(
    input  operand_t      opa,
    input  operand_t      opb,
    input  logic          pick_max,
    output logic [DW-1:0] res,
    output logic          res_sgn
);
    logic [DW:0] a_w_d, b_w_d, r_w_d;
    logic        a_lt_b_d;

    always_comb begin
        a_w_d    = {opa.sgn & opa.value[DW-1], opa.value};
        b_w_d    = {opb.sgn & opb.value[DW-1], opb.value};
        a_lt_b_d = $signed(a_w_d) < $signed(b_w_d);
        res      = (pick_max ^ a_lt_b_d) ? opa.value : opb.value;
        res_sgn  = (opa.sgn == opb.sgn) ? opa.sgn : ~pick_max;
    end

    // the pick read back in its own signedness must bound both inputs
    always_comb begin
        r_w_d = {res_sgn & res[DW-1], res};
        assert_pick_bound_R4: assert (pick_max
            ? ($signed(r_w_d) >= $signed(a_w_d) && $signed(r_w_d) >= $signed(b_w_d))
            : ($signed(r_w_d) <= $signed(a_w_d) && $signed(r_w_d) <= $signed(b_w_d)));
    end
endmodule

// File: rtl/lmm_sat.sv
module lmm_sat
    import lmm_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic          val_sgn,
    input  logic          sat_en,
    input  logic          dst_signed,
    output logic [DW-1:0] out
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    always_comb begin
        out = val;
        if (sat_en && dst_signed && !val_sgn && val > SMAX) begin
            out = SMAX;
        end else if (sat_en && !dst_signed && val_sgn && val[DW-1]) begin
            out = '0;
        end
    end

    always_comb begin
        if (sat_en && dst_signed && !val_sgn) begin
            assert_sat_upper_R6: assert (!out[DW-1]);
        end
        if (sat_en && !dst_signed && val_sgn) begin
            assert_sat_floor_R7: assert (!out[DW-1]);
        end
    end
endmodule

// File: rtl/lmm_post.sv
module lmm_post
    import lmm_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] opc,
    input  logic          dst_signed,
    input  post_e         mode,
    output logic [DW-1:0] out
);
    logic val_lt_c_d;
    logic [DW-1:0] keep_mask_d;

    always_comb begin
        val_lt_c_d = dst_signed ? ($signed(val) < $signed(opc)) : (val < opc);
        case (mode)
            POST_ADD:     out = val + opc;
            POST_MAX:     out = val_lt_c_d ? opc : val;
            POST_MIN:     out = val_lt_c_d ? val : opc;
            POST_INS_H16: out = {val[HW-1:0], opc[HW-1:0]};
            POST_INS_L16: out = {opc[DW-1:HW], val[HW-1:0]};
            POST_INS_B0:  out = {opc[DW-1:BW], val[BW-1:0]};
            POST_INS_B2:  out = {opc[DW-1:HW+BW], val[BW-1:0], opc[HW-1:0]};
            default:      out = val;
        endcase
    end

    // bits outside the written lane must keep C
    always_comb begin
        keep_mask_d = '1;
        if (mode == POST_INS_H16) keep_mask_d = {{HW{1'b0}}, {HW{1'b1}}};
        if (mode == POST_INS_L16) keep_mask_d = {{HW{1'b1}}, {HW{1'b0}}};
        if (mode == POST_INS_B0)  keep_mask_d = ~{{(DW-BW){1'b0}}, {BW{1'b1}}};
        if (mode == POST_INS_B2)  keep_mask_d = ~({{(DW-BW){1'b0}}, {BW{1'b1}}} << HW);
        if (mode inside {POST_INS_H16, POST_INS_L16, POST_INS_B0, POST_INS_B2}) begin
            assert_merge_keeps_c_R11: assert ((out & keep_mask_d) == (opc & keep_mask_d));
        end
    end
endmodule

// File: rtl/lane_minmax_alu.sv
module lane_minmax_alu
    import lmm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   src_a,
    input  logic [31:0]   src_b,
    input  logic [31:0]   src_c,
    input  logic [15:0]   imm,
    input  logic [2:0]    a_lane,
    input  logic          a_signed,
    input  logic [2:0]    b_lane,
    input  logic          b_signed,
    input  logic          b_use_imm,
    input  logic          pick_max,
    input  logic          sat_en,
    input  logic          dst_signed,
    input  logic [2:0]    post_sel,
    output logic [31:0]   result
);
    typedef struct packed {
        logic [DW-1:0] result;
    } state_t;

    operand_t      a_op, b_reg_op, b_op;
    logic [DW-1:0] pick_v, sat_v, post_v;
    logic          pick_sgn;
    state_t        state_d, state_q;

    lmm_lane_ext u_ext_a (.word(src_a), .lane(a_lane), .sgn(a_signed), .opnd(a_op));
    lmm_lane_ext u_ext_b (.word(src_b), .lane(b_lane), .sgn(b_signed), .opnd(b_reg_op));

    always_comb begin
        b_op = b_reg_op;
        if (b_use_imm) begin
            b_op.value = {{(DW-HW){b_signed & imm[HW-1]}}, imm};
            b_op.sgn   = b_signed;
        end
    end

    lmm_pick u_pick (.opa(a_op), .opb(b_op), .pick_max(pick_max),
                     .res(pick_v), .res_sgn(pick_sgn));

    lmm_sat u_sat (.val(pick_v), .val_sgn(pick_sgn), .sat_en(sat_en),
                   .dst_signed(dst_signed), .out(sat_v));

    lmm_post u_post (.val(sat_v), .opc(src_c), .dst_signed(dst_signed),
                     .mode(post_e'(post_sel)), .out(post_v));

    always_comb begin
        state_d        = state_q;
        state_d.result = post_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    generate
        if (OUT_REG) begin : g_reg
            assign result = state_q.result;
        end else begin : g_comb
            assign result = state_d.result;
        end
    endgenerate
endmodule

// File: tb/sim_lane_minmax_alu.sv
module sim_lane_minmax_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0;
    logic [15:0] imm = '0;
    logic [2:0]  a_lane = '0, b_lane = '0, post_sel = '0;
    logic        a_signed = 0, b_signed = 0, b_use_imm = 0, pick_max = 0, sat_en = 0, dst_signed = 0;
    logic [31:0] result;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lane_minmax_alu u0 (.clk, .rst_n, .src_a, .src_b, .src_c, .imm, .a_lane, .a_signed,
        .b_lane, .b_signed, .b_use_imm, .pick_max, .sat_en, .dst_signed, .post_sel, .result);

    task automatic check(input logic [31:0] exp, input string tag);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, result, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, b, c, input logic [15:0] im,
                       input logic [2:0] al, input logic as, input logic [2:0] bl, input logic bs,
                       input logic bi, mx, st, ds, input logic [2:0] ps);
        src_a = a; src_b = b; src_c = c; imm = im; a_lane = al; a_signed = as;
        b_lane = bl; b_signed = bs; b_use_imm = bi; pick_max = mx; sat_en = st;
        dst_signed = ds; post_sel = ps;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        check(32'h0, "R12 reset");
    endtask

    task automatic t_lanes;
        run(32'h80F17F23, 0, 0, 16'h7FFF, 3'd1, 1, 0, 1, 1, 0, 0, 0, 0); check(32'h0000007F, "R1 byte1 signed");
        run(32'h80F17F23, 0, 0, 16'h7FFF, 3'd2, 1, 0, 1, 1, 0, 0, 0, 0); check(32'hFFFFFFF1, "R1 byte2 signed");
        run(32'h80F17F23, 0, 0, 16'hFFFF, 3'd2, 0, 0, 0, 1, 0, 0, 0, 0); check(32'h000000F1, "R1 byte2 unsigned");
        run(32'h80F17F23, 0, 0, 16'h7FFF, 3'd5, 1, 0, 1, 1, 0, 0, 0, 0); check(32'hFFFF80F1, "R1 half1 signed");
        run(32'h80F17F23, 0, 0, 16'hFFFF, 3'd4, 0, 0, 0, 1, 0, 0, 0, 0); check(32'h00007F23, "R1 half0 unsigned");
        run(32'h80F17F23, 0, 0, 16'h0000, 3'd6, 0, 0, 0, 1, 1, 0, 0, 0); check(32'h80F17F23, "R1 word");
    endtask

    task automatic t_imm;
        run(0, 32'hFFFFFFFF, 0, 16'h8000, 3'd6, 1, 3'd0, 1, 1, 0, 0, 0, 0); check(32'hFFFF8000, "R2 imm sign-ext");
        run(0, 32'hFFFFFFFF, 0, 16'h8000, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 0); check(32'h00008000, "R2 imm zero-ext, src_b ignored");
    endtask

    task automatic t_same;
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 1, 3'd6, 1, 0, 1, 0, 0, 0); check(32'h00000003, "R3 signed max");
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 1, 3'd6, 1, 0, 0, 0, 0, 0); check(32'hFFFFFFFE, "R3 signed min");
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 0, 0); check(32'hFFFFFFFE, "R3 unsigned max");
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 0, 3'd6, 0, 0, 0, 0, 0, 0); check(32'h00000003, "R3 unsigned min");
    endtask

    task automatic t_mixed;
        run(32'h80000000, 5, 0, 0, 3'd6, 0, 3'd6, 1, 0, 1, 0, 0, 0); check(32'h80000000, "R4 mixed max");
        run(32'h80000000, 5, 0, 0, 3'd6, 0, 3'd6, 1, 0, 0, 0, 0, 0); check(32'h00000005, "R4 mixed min");
        run(32'h80000000, 32'hFFFFFFFD, 0, 0, 3'd6, 0, 3'd6, 1, 0, 0, 0, 0, 0); check(32'hFFFFFFFD, "R4 mixed min negative");
        run(32'hFFFFFFFD, 7, 0, 0, 3'd6, 1, 3'd6, 0, 0, 1, 0, 0, 0); check(32'h00000007, "R4 mixed max swapped");
    endtask

    task automatic t_sat;
        run(32'h80000000, 5, 0, 0, 3'd6, 0, 3'd6, 1, 0, 1, 1, 1, 0); check(32'h7FFFFFFF, "R5 R6 mixed max clamped high");
        run(32'h80000000, 32'hFFFFFFFD, 0, 0, 3'd6, 0, 3'd6, 1, 0, 0, 1, 0, 0); check(32'h00000000, "R5 R7 mixed min clamped to 0");
        run(32'h80000000, 32'hFFFFFFFD, 0, 0, 3'd6, 0, 3'd6, 1, 0, 0, 1, 1, 0); check(32'hFFFFFFFD, "R8 signed pick, signed dst");
        run(32'h80000000, 5, 0, 0, 3'd6, 0, 3'd6, 1, 0, 1, 1, 0, 0); check(32'h80000000, "R8 unsigned pick, unsigned dst");
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 1, 3'd6, 1, 0, 0, 1, 0, 0); check(32'h00000000, "R7 signed min clamped");
        run(32'hFFFFFFFE, 3, 0, 0, 3'd6, 1, 3'd6, 1, 0, 1, 1, 0, 0); check(32'h00000003, "R7 positive unchanged");
    endtask

    task automatic t_post;
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 0, 3'd1); check(32'h00000010, "R9 add wraps");
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 1, 3'd2); check(32'h00000020, "R10 max signed");
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 0, 3'd2); check(32'hFFFFFFF0, "R10 max unsigned");
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 1, 3'd3); check(32'hFFFFFFF0, "R10 min signed");
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 0, 3'd3); check(32'h00000020, "R10 min unsigned");
        run(32'h10, 32'h20, 32'hFFFFFFF0, 0, 3'd6, 0, 3'd6, 0, 0, 1, 0, 0, 3'd0); check(32'h00000020, "R10 none");
    endtask

    task automatic t_merge;
        run(32'h1234ABCD, 0, 32'hFFFFFFFF, 0, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 3'd4); check(32'hABCDFFFF, "R11 half high");
        run(32'h1234ABCD, 0, 32'hFFFFFFFF, 0, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 3'd5); check(32'hFFFFABCD, "R11 half low");
        run(32'h1234ABCD, 0, 32'hFFFFFFFF, 0, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 3'd6); check(32'hFFFFFFCD, "R11 byte 0");
        run(32'h1234ABCD, 0, 32'hFFFFFFFF, 0, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 3'd7); check(32'hFFCDFFFF, "R11 byte 2");
    endtask

    task automatic t_combined;
        run(32'h80000000, 5, 32'h1, 0, 3'd6, 0, 3'd6, 1, 0, 1, 1, 1, 3'd1); check(32'h80000000, "R6 R9 clamp then add");
        run(32'h80000000, 32'hFFFFFFFD, 32'hFFFFFFFF, 0, 3'd6, 0, 3'd6, 1, 0, 0, 1, 0, 3'd6); check(32'hFFFFFF00, "R7 R11 clamp then merge");
    endtask

    task automatic t_hold;
        run(32'h55, 0, 0, 0, 3'd6, 0, 3'd6, 0, 1, 1, 0, 0, 0); check(32'h00000055, "R12 registered");
        src_a = 32'h99;
        #5;
        check(32'h00000055, "R12 holds between edges");
        @(posedge clk); @(negedge clk);
        check(32'h00000099, "R12 update next edge");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lanes(); t_imm(); t_same(); t_mixed(); t_sat(); t_post(); t_merge(); t_combined(); t_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule